// File: doc/BRIEF.md
# DRAM Refresh Bus Stall Scheduler

This block places one memory-refresh window on every raster line and, for the whole of that window, takes the system bus away from both the processor and the DMA engine. It watches the horizontal position, the start-of-line strobe and a short-line flag coming from the raster timing generator. A revision select picks how the window is placed. On an early chip the window sits at a fixed position. On later chips it alternates between two positions from one line to the next.

Outside the window the block acts as a small two-requester grant unit. DMA is favoured over the processor. A request that arrives while the window is open is remembered, not lost. It is granted on the first clock after the window closes. Row addressing and memory electrical timing are left to other logic.

Top module: `refresh_stall_sched`

## Requirements
- R1: Every line carries exactly one refresh window, and `refresh_active` is high for exactly 40 contiguous clocks within it.
- R2: With `chip_rev_early`=1, the window starts at `hpos`=530 on every line.
- R3: With `chip_rev_early`=0, the window start alternates between `hpos`=538 and `hpos`=534 on successive lines. The first line that begins with a `line_start` pulse after reset uses 538.
- R4: `short_line` is held high for the whole of a short line. The line after a short line uses the same start position as the short line, so the alternation does not advance across it.
- R5: While the window is open, `bus_stall` is 1 and neither `cpu_grant` nor `dma_grant` is given, whatever the requests are.
- R6: The processor has 1324 stall-free clocks on a 1364-clock line and 1320 on a 1360-clock short line.
- R7: A one-clock request pulse arriving during the window is held. It is granted on the first clock after the window. When both requesters are waiting, DMA is granted first and the processor on the next clock. At most one grant is high in any clock.
- R8: Synchronous active-low reset clears the held requests, leaves `bus_stall` and both grants low, and restarts the alternation so that the next line uses 538.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hpos | input | 11 | Horizontal position within the current line |
| line_start | input | 1 | One-clock pulse on the first clock of a line (hpos 0) |
| short_line | input | 1 | High for the whole of a short line |
| chip_rev_early | input | 1 | 1 selects the fixed placement rule, 0 the alternating rule |
| cpu_req | input | 1 | Processor bus request |
| dma_req | input | 1 | DMA bus request |
| refresh_active | output | 1 | High while the refresh window is open |
| bus_stall | output | 1 | Blocks processor and DMA bus cycles during the window |
| cpu_grant | output | 1 | Processor bus cycle granted this clock |
| dma_grant | output | 1 | DMA bus cycle granted this clock |

## Verification
The bench runs a series of whole lines. The series mixes the two revision rules, full-length and short lines, and switches between the rules in the middle. For each line it checks the first stalled position, the length of the stall, that the stall is one contiguous run, and the count of free clocks. Those checks separate a fixed start from an alternating one, and an alternation that wrongly advances across a short line from one that holds. Directed tests inject processor and DMA pulses inside an open window, which shows whether requests are dropped, granted too early, or granted in the wrong order. A reset given in the middle of a run shows whether the alternation restarts at 538.

// File: rtl/refsched_pkg.sv
// Shared constants and the phase type for the refresh stall scheduler.
// Assumes an 11-bit horizontal counter covering lines of up to 2047 clocks.
package refsched_pkg;
    localparam int HPOS_W      = 11;
    localparam int WIN_CLOCKS  = 40;
    localparam int POS_EARLY   = 530;
    localparam int POS_EVEN    = 538;
    localparam int POS_ODD     = 534;

    // Which of the two alternating positions the current line uses.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } alt_phase_e;
endpackage

// File: rtl/refresh_phase.sv
// Tracks the alternation phase for the later-revision placement rule.
// Assumes line_start pulses once, on the first clock of each line.
// Assumes short_line is a level that is valid for the whole current line.
// The phase is left alone at the first line_start after reset and after a short line.
module refresh_phase
    import refsched_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       short_line,
    output alt_phase_e phase
);
    logic seen_line;
    logic short_prev;

    // Update the phase at each line boundary, skipping it after a short line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_line  <= 1'b0;
            short_prev <= 1'b0;
            phase      <= PH_FIRST;
        end else begin
            short_prev <= short_line;
            if (line_start) begin
                seen_line <= 1'b1;
                if (seen_line && !short_prev) begin
                    phase <= (phase == PH_FIRST) ? PH_SECOND : PH_FIRST;
                end
            end
        end
    end

    // R4: the phase keeps its value across a line boundary that ends a short line.
    p_short_keeps_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && short_prev) |=> $stable(phase));
endmodule

// File: rtl/refresh_window.sv
// Decodes the refresh window from the horizontal position and the placement rule.
// Assumes hpos counts up by one per clock and that the window fits inside the line.
module refresh_window
    import refsched_pkg::*;
#(
    parameter int HW        = HPOS_W,
    parameter int WIN_LEN   = WIN_CLOCKS,
    parameter int S_EARLY   = POS_EARLY,
    parameter int S_FIRST   = POS_EVEN,
    parameter int S_SECOND  = POS_ODD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hpos,
    input  logic          rev_early,
    input  alt_phase_e    phase,
    output logic          active
);
    localparam int EW = HW + 1;
    localparam int CW = $clog2(WIN_LEN + 1) + 1;

    logic [EW-1:0] start_pos;
    logic [EW-1:0] pos_ext;
    logic [CW-1:0] run_cnt;

    // Pick the start position for the current line.
    always_comb begin
        if (rev_early)                start_pos = EW'(S_EARLY);
        else if (phase == PH_FIRST)   start_pos = EW'(S_FIRST);
        else                          start_pos = EW'(S_SECOND);
    end

    // The window is open from the start position for WIN_LEN clocks.
    always_comb begin
        pos_ext = {1'b0, hpos};
        active  = (pos_ext >= start_pos) && (pos_ext < start_pos + EW'(WIN_LEN));
    end

    // Length of the current open run, kept only for the length check below.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_cnt <= '0;
        else if (active) run_cnt <= run_cnt + 1'b1;
        else             run_cnt <= '0;
    end

    // R1: every window that closes was open for exactly WIN_LEN clocks.
    p_window_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (run_cnt == CW'(WIN_LEN)));

    // R2: under the early rule the window opens at the fixed position.
    p_early_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && rev_early) |-> ({1'b0, hpos} == EW'(S_EARLY)));

    // R3: under the later rule the window opens at one of the two positions.
    p_alt_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(active) && !rev_early) |->
            (({1'b0, hpos} == EW'(S_FIRST)) || ({1'b0, hpos} == EW'(S_SECOND))));
endmodule

// File: rtl/bus_grant.sv
// Grants the bus to DMA or the processor whenever no refresh stall is active.
// DMA has priority over the processor.
// Assumes requests may be single-clock pulses.
// A request that is not granted is held until it is granted.
module bus_grant (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    input  logic cpu_req,
    input  logic dma_req,
    output logic cpu_grant,
    output logic dma_grant
);
    logic cpu_hold;
    logic dma_hold;
    logic cpu_want;
    logic dma_want;

    // Merge live requests with held ones and resolve the priority.
    always_comb begin
        cpu_want  = cpu_req | cpu_hold;
        dma_want  = dma_req | dma_hold;
        dma_grant = dma_want & ~stall;
        cpu_grant = cpu_want & ~stall & ~dma_want;
    end

    // Keep every request that was not granted this clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_hold <= 1'b0;
            dma_hold <= 1'b0;
        end else begin
            cpu_hold <= cpu_want & ~cpu_grant;
            dma_hold <= dma_want & ~dma_grant;
        end
    end

    // R7: never more than one grant in the same clock.
    p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_grant, dma_grant}));

    // R7: a request held through the window is served on the clock the stall drops.
    p_held_served_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stall) && ($past(cpu_hold) || $past(dma_hold))) |-> (cpu_grant || dma_grant));
endmodule

// File: rtl/refresh_stall_sched.sv
// Top of the refresh stall scheduler: phase tracking, window decode and bus grant.
// Assumes the raster generator drives hpos, line_start and short_line in step.
module refresh_stall_sched
    import refsched_pkg::*;
#(
    parameter int HW       = HPOS_W,
    parameter int WIN_LEN  = WIN_CLOCKS,
    parameter int S_EARLY  = POS_EARLY,
    parameter int S_FIRST  = POS_EVEN,
    parameter int S_SECOND = POS_ODD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hpos,
    input  logic          line_start,
    input  logic          short_line,
    input  logic          chip_rev_early,
    input  logic          cpu_req,
    input  logic          dma_req,
    output logic          refresh_active,
    output logic          bus_stall,
    output logic          cpu_grant,
    output logic          dma_grant
);
    alt_phase_e phase;

    refresh_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .short_line (short_line),
        .phase      (phase)
    );

    refresh_window #(
        .HW       (HW),
        .WIN_LEN  (WIN_LEN),
        .S_EARLY  (S_EARLY),
        .S_FIRST  (S_FIRST),
        .S_SECOND (S_SECOND)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .hpos      (hpos),
        .rev_early (chip_rev_early),
        .phase     (phase),
        .active    (refresh_active)
    );

    // The stall covers the whole window and nothing else.
    always_comb bus_stall = refresh_active;

    bus_grant u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (bus_stall),
        .cpu_req   (cpu_req),
        .dma_req   (dma_req),
        .cpu_grant (cpu_grant),
        .dma_grant (dma_grant)
    );

    // R5: no bus cycle is granted to either requester while the stall is up.
    p_stall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stall |-> (!cpu_grant && !dma_grant));
endmodule

// File: tb/tb_refresh_stall_sched.sv
module tb_refresh_stall_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    localparam int LEN_FULL  = 1364;
    localparam int LEN_SHORT = 1360;

    // Line table: revision rule, short flag, expected first stalled position.
    localparam int V_REV   [NVEC] = '{0, 0, 0, 0, 0, 1, 0, 1, 0};
    localparam int V_SHORT [NVEC] = '{0, 0, 1, 0, 0, 0, 0, 1, 0};
    localparam int V_START [NVEC] = '{538, 534, 538, 538, 534, 530, 534, 530, 538};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] hpos = '0;
    logic        line_start = 1'b0;
    logic        short_line = 1'b0;
    logic        chip_rev_early = 1'b0;
    logic        cpu_req = 1'b0;
    logic        dma_req = 1'b0;
    logic        refresh_active;
    logic        bus_stall;
    logic        cpu_grant;
    logic        dma_grant;

    int errors = 0;
    int checks = 0;
    logic s_stall, s_act, s_cg, s_dg;

    refresh_stall_sched dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hpos           (hpos),
        .line_start     (line_start),
        .short_line     (short_line),
        .chip_rev_early (chip_rev_early),
        .cpu_req        (cpu_req),
        .dma_req        (dma_req),
        .refresh_active (refresh_active),
        .bus_stall      (bus_stall),
        .cpu_grant      (cpu_grant),
        .dma_grant      (dma_grant)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: drive inputs just after an edge, sample a quarter period later.
    task automatic cyc(input int h, input bit ls, input bit sh, input bit rev,
                       input bit cr, input bit dr);
        hpos = 11'(h); line_start = ls; short_line = sh; chip_rev_early = rev;
        cpu_req = cr; dma_req = dr;
        #(CLK_PERIOD / 4);
        s_stall = bus_stall; s_act = refresh_active; s_cg = cpu_grant; s_dg = dma_grant;
        @(posedge clk); #1;
    endtask

    task automatic run_line(input bit rev, input bit sh, input int len,
                            output int first, output int cnt, output int runs);
        bit prev = 1'b0;
        first = -1; cnt = 0; runs = 0;
        for (int h = 0; h < len; h++) begin
            cyc(h, h == 0, sh, rev, 1'b0, 1'b0);
            if (s_stall) begin
                if (cnt == 0) first = h;
                cnt++;
                if (!prev) runs++;
            end
            prev = s_stall;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) cyc(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int first, cnt, runs, len;
        @(posedge clk); #1;
        do_reset();

        // R8: reset state at the ports
        cyc(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(!s_stall && !s_cg && !s_dg, "R8 reset outputs low", {s_stall, s_cg, s_dg}, 0);

        // Table walk over full and short lines with both placement rules
        for (int v = 0; v < NVEC; v++) begin
            len = V_SHORT[v] ? LEN_SHORT : LEN_FULL;
            run_line(V_REV[v] != 0, V_SHORT[v] != 0, len, first, cnt, runs);
            chk(first == V_START[v], V_REV[v] ? "R2 early start" :
                (V_SHORT[v] != 0 || (v > 0 && V_SHORT[v-1] != 0)) ? "R4 short line start" :
                "R3 alternating start", first, V_START[v]);
            chk(cnt == 40 && runs == 1, "R1 single 40-clock window", cnt * 10 + runs, 401);
            chk(len - cnt == (V_SHORT[v] ? 1320 : 1324), "R6 free clocks",
                len - cnt, V_SHORT[v] ? 1320 : 1324);
        end

        // R8: reset mid-run, the next line must use 538 again
        do_reset();
        run_line(1'b0, 1'b0, LEN_FULL, first, cnt, runs);
        chk(first == 538, "R8 phase restart", first, 538);

        // R5/R7: requests during the window of the first line after a reset (538..577)
        do_reset();
        for (int h = 0; h < LEN_FULL; h++) begin
            cyc(h, h == 0, 1'b0, 1'b0, h == 540, h == 550);
            if (h == 540) chk(!s_cg && s_stall, "R5 cpu blocked in window", s_cg, 0);
            if (h == 550) chk(!s_dg && s_stall, "R5 dma blocked in window", s_dg, 0);
            if (h == 577) chk(s_stall && !s_cg && !s_dg, "R5 last window clock",
                              {s_stall, s_cg, s_dg}, 4);
            if (h == 578) chk(s_dg && !s_cg && !s_stall, "R7 dma first after window",
                              {s_dg, s_cg}, 2);
            if (h == 579) chk(s_cg && !s_dg, "R7 cpu next clock", {s_dg, s_cg}, 1);
            if (h == 580) chk(!s_cg && !s_dg, "R7 held requests cleared", {s_dg, s_cg}, 0);
        end

        // R7: a processor pulse alone in the window of a later-rule line (534..573)
        for (int h = 0; h < LEN_FULL; h++) begin
            cyc(h, h == 0, 1'b0, 1'b0, h == 560, 1'b0);
            if (h == 573) chk(!s_cg, "R7 cpu held at window end", s_cg, 0);
            if (h == 574) chk(s_cg, "R7 cpu granted after window", s_cg, 1);
        end

        // R7: outside the window a live request is granted at once
        cyc(100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(s_cg && !s_dg, "R7 cpu immediate grant", s_cg, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule